// File: doc/BRIEF.md
# Bus Phase Sequencer with Settle Timing

This block drives the three phase lines (message, command/data, input/output) of a bus target and sequences every change between information transfer phases. A phase change is requested with a 4-bit code and a one-cycle strobe. The block holds the change off while the initiator still asserts ACK. It then switches all three lines in one clock edge and stays busy for a settle period. The period's length depends on whether the I/O direction flipped and on a legacy-host mode. In legacy mode, entering a data phase is also preceded by a long extra wait.

A glitch-filtered bus reset detector is built in. It feeds a sticky reset flag. The same flag is forced when a phase change is applied while the transfer engine is not idle. The flag cuts short any wait for ACK. It is cleared when a bus-free (release) request is applied. All delays are given in nanoseconds and are turned into clock cycles from a clock-frequency parameter. With the default 125 MHz the values are:

| Delay | Cycles |
|---|---|
| 400 ns base settle | 50 |
| 400 ns I/O release | 50 |
| 100 µs legacy settle | 12500 |
| 400 µs legacy data wait | 50000 |
| 500 ns reset filter | 63 |

Top module: `bus_phase_seq`

## Requirements
- R1: After reset the phase lines are 0, the control enable is 0, busy is 0 and the reset flag is 0. The current phase is "released".
- R2: A strobe whose code equals the current phase completes at once: busy stays 0 and the lines do not move. All codes with bit 3 set are equal to each other. A code with bit 3 clear equals the current phase when bits 2..0 match the current lines {MSG,C/D,I/O}.
- R3: After a strobe with a different code, the lines hold their old value while ACK is high. They take the new value at the first clock edge after the strobe edge at which ACK is sampled low. Busy is 1 from the strobe edge onwards.
- R4: MSG, C/D and I/O change at the same clock edge. A non-release code drives MSG = bit 2, C/D = bit 1, I/O = bit 0, and sets the control enable to 1.
- R5: After the lines change, busy falls 50 cycles later (400 ns base settle) when neither of the extra terms applies.
- R6: If I/O differs between the old and the new lines, 50 cycles (400 ns) are added to the settle period.
- R7: With legacy mode high, 12500 cycles (100 µs) are added to the settle period.
- R8: With legacy mode high, a change to a data phase (bits 2..1 equal 00) first waits 50000 cycles (400 µs) after ACK is released. Only then do the lines change.
- R9: A release code (bit 3 set) drives all lines and the control enable to 0. Busy falls at the same edge, with no settle period.
- R10: If the transfer engine is not idle when the change would be applied, the lines stay unchanged, the reset flag is set and busy falls.
- R11: A rising edge of the active-high bus reset input arms a 63-cycle (500 ns) filter, but only while the target's own SEL output is not driven. The flag is set only if reset is still high when the filter expires. Shorter glitches are ignored, and so are edges that occur while SEL is driven.
- R12: While the reset flag is set, the wait for ACK is abandoned and the change proceeds.
- R13: Applying a release request clears the reset flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_code_i | input | 4 | Requested phase: bit 3 = release, bits 2..0 = {MSG,C/D,I/O} |
| req_stb_i | input | 1 | One-cycle phase change request |
| ack_i | input | 1 | Synchronised ACK from initiator, active high |
| bus_rst_i | input | 1 | Synchronised bus reset, active high |
| sel_drive_i | input | 1 | Target is driving its own SEL output |
| legacy_i | input | 1 | Legacy-host timing mode |
| dma_idle_i | input | 1 | Transfer engine is idle |
| msg_o | output | 1 | MSG phase line |
| cd_o | output | 1 | C/D phase line |
| io_o | output | 1 | I/O phase line |
| ctl_oe_o | output | 1 | Control output enable |
| busy_o | output | 1 | Phase change in progress |
| rst_flag_o | output | 1 | Sticky bus reset / forced reset flag |

## Verification
A strobe is captured at edge S. With ACK low, the lines and the enable change at edge S+1. Busy then falls at edge S+1+N, where N is the settle sum. In legacy data entries the lines instead change at S+1+50000. A reset edge seen at edge E sets the flag at E+63. The bench drives inputs on falling edges and samples on falling edges. Each timing check tests the value one cycle before the due edge and again right after it, so that an off-by-one in any count is caught.

// File: rtl/bps_pkg.sv
package bps_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_LEG,
    S_SETTLE
  } seq_state_t;

  // data phases have MSG = 0 and C/D = 0
  function automatic logic is_data(input logic [2:0] ph);
    return ph[2:1] == 2'b00;
  endfunction

  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/bps_down_timer.sv
module bps_down_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         active_o,
  output logic         last_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i)                cnt <= '0;
    else if (load_i)          cnt <= load_val_i;
    else if (cnt != '0)       cnt <= cnt - W'(1);
  end

  assign active_o = (cnt != '0);
  assign last_o   = (cnt == W'(1));

  // R5: a load of zero would never expire
  a_r5_load_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |-> (load_val_i != '0));

endmodule

// File: rtl/bps_rst_filter.sv
module bps_rst_filter #(
  parameter int FILT_CYC = 63
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bus_rst_i,
  input  logic sel_drive_i,
  output logic confirm_o
);
  localparam int FW = $clog2(FILT_CYC + 1) + 1;

  logic prev_q;
  logic start, t_active, t_last;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= bus_rst_i;
  end

  assign start = bus_rst_i & ~prev_q & ~sel_drive_i & ~t_active;

  bps_down_timer #(.W(FW)) u_tmr (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (start),
    .load_val_i (FW'(FILT_CYC)),
    .active_o   (t_active),
    .last_o     (t_last)
  );

  assign confirm_o = t_last & bus_rst_i;

  // R11: no confirmation without an armed filter window
  a_r11_needs_arm: assert property (@(posedge clk_i) disable iff (rst_i)
    (!t_active && (sel_drive_i || !bus_rst_i)) |=> !confirm_o);

endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
  import bps_pkg::*;
#(
  parameter int CLK_MHZ      = 125,
  parameter int BASE_NS      = 400,
  parameter int IO_NS        = 400,
  parameter int LEG_SETTLE_NS = 100000,
  parameter int LEG_DATA_NS  = 400000,
  parameter int RST_FILT_NS  = 500
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [3:0] req_code_i,
  input  logic       req_stb_i,
  input  logic       ack_i,
  input  logic       bus_rst_i,
  input  logic       sel_drive_i,
  input  logic       legacy_i,
  input  logic       dma_idle_i,
  output logic       msg_o,
  output logic       cd_o,
  output logic       io_o,
  output logic       ctl_oe_o,
  output logic       busy_o,
  output logic       rst_flag_o
);
  localparam int BASE_CYC = ns_to_cyc(BASE_NS, CLK_MHZ);
  localparam int IO_CYC   = ns_to_cyc(IO_NS, CLK_MHZ);
  localparam int LS_CYC   = ns_to_cyc(LEG_SETTLE_NS, CLK_MHZ);
  localparam int LD_CYC   = ns_to_cyc(LEG_DATA_NS, CLK_MHZ);
  localparam int RF_CYC   = ns_to_cyc(RST_FILT_NS, CLK_MHZ);
  localparam int MAX_SET  = BASE_CYC + IO_CYC + LS_CYC;
  localparam int MAX_CYC  = (LD_CYC > MAX_SET) ? LD_CYC : MAX_SET;
  localparam int TW       = $clog2(MAX_CYC + 1) + 1;

  seq_state_t state;
  logic [3:0] pend_q;
  logic       cur_rel_q;
  logic       same, go, leg_data, apply_now;
  logic       tmr_load, tmr_active, tmr_last, rst_confirm;
  logic [TW-1:0] tmr_val, settle_val;

  assign same = req_code_i[3] ? cur_rel_q
                              : (!cur_rel_q && req_code_i[2:0] == {msg_o, cd_o, io_o});
  assign go        = (state == S_WAIT) && (!ack_i || rst_flag_o);
  assign leg_data  = !pend_q[3] && legacy_i && is_data(pend_q[2:0]);
  assign apply_now = (go && !leg_data) || ((state == S_LEG) && tmr_last);

  always_comb begin
    settle_val = TW'(BASE_CYC);
    if (pend_q[0] != io_o) settle_val = settle_val + TW'(IO_CYC);
    if (legacy_i)          settle_val = settle_val + TW'(LS_CYC);
  end

  assign tmr_load = (go && leg_data) || (apply_now && dma_idle_i && !pend_q[3]);
  assign tmr_val  = (go && leg_data) ? TW'(LD_CYC) : settle_val;

  bps_down_timer #(.W(TW)) u_tmr (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .active_o   (tmr_active),
    .last_o     (tmr_last)
  );

  bps_rst_filter #(.FILT_CYC(RF_CYC)) u_rflt (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .bus_rst_i   (bus_rst_i),
    .sel_drive_i (sel_drive_i),
    .confirm_o   (rst_confirm)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state      <= S_IDLE;
      pend_q     <= 4'b1000;
      cur_rel_q  <= 1'b1;
      msg_o      <= 1'b0;
      cd_o       <= 1'b0;
      io_o       <= 1'b0;
      ctl_oe_o   <= 1'b0;
      busy_o     <= 1'b0;
      rst_flag_o <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_stb_i && !same) begin
          pend_q <= req_code_i;
          busy_o <= 1'b1;
          state  <= S_WAIT;
        end
        S_WAIT: if (go && leg_data) state <= S_LEG;
        S_SETTLE: if (tmr_last) begin
          busy_o <= 1'b0;
          state  <= S_IDLE;
        end
        default: ;
      endcase
      if (apply_now) begin
        if (!dma_idle_i) begin
          rst_flag_o <= 1'b1;
          busy_o     <= 1'b0;
          state      <= S_IDLE;
        end else if (pend_q[3]) begin
          {msg_o, cd_o, io_o} <= 3'b000;
          ctl_oe_o   <= 1'b0;
          cur_rel_q  <= 1'b1;
          rst_flag_o <= 1'b0;
          busy_o     <= 1'b0;
          state      <= S_IDLE;
        end else begin
          {msg_o, cd_o, io_o} <= pend_q[2:0];
          ctl_oe_o  <= 1'b1;
          cur_rel_q <= 1'b0;
          state     <= S_SETTLE;
        end
      end
      if (rst_confirm) rst_flag_o <= 1'b1;
    end
  end

  // R3: lines frozen while ACK holds the change off
  a_r3_ack_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == S_WAIT && ack_i && !rst_flag_o) |=> $stable({msg_o, cd_o, io_o}));
  // R4: lines move only inside a busy sequence
  a_r4_lines_need_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable({msg_o, cd_o, io_o}) |-> $past(busy_o));
  // R2: same-phase request never raises busy
  a_r2_same_no_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == S_IDLE && req_stb_i && same) |=> !busy_o);
  // R10: non-idle transfer engine forces the flag
  a_r10_dma_force: assert property (@(posedge clk_i) disable iff (rst_i)
    (apply_now && !dma_idle_i) |=> (rst_flag_o && !busy_o));
  // R5: settle state always has a running count
  a_r5_settle_timer: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == S_SETTLE) |-> tmr_active);

endmodule

// File: tb/test_bus_phase_seq.sv
`timescale 1ns/1ps
module test_bus_phase_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] code = 4'b0;
  logic stb = 0, ack = 0, brst = 0, seld = 0, leg = 0, dmai = 1;
  logic msg, cd, io, oe, busy, flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_phase_seq i_bus_phase_seq (
    .clk_i(clk), .rst_i(rst), .req_code_i(code), .req_stb_i(stb),
    .ack_i(ack), .bus_rst_i(brst), .sel_drive_i(seld), .legacy_i(leg),
    .dma_idle_i(dmai), .msg_o(msg), .cd_o(cd), .io_o(io),
    .ctl_oe_o(oe), .busy_o(busy), .rst_flag_o(flag));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lines();
    return {msg, cd, io};
  endfunction

  // strobe captured at edge S; returns at the falling edge after S
  task automatic strobe(input logic [3:0] c);
    @(negedge clk); code = c; stb = 1;
    @(negedge clk); stb = 0;
  endtask

  task automatic wait_settle(input int n, input string req);
    repeat (n - 1) @(negedge clk);
    check(busy === 1'b1, req, busy, 1);
    @(negedge clk);
    check(busy === 1'b0, req, busy, 0);
  endtask

  task automatic t_enter(input logic [2:0] ph, input int n, input string req);
    strobe({1'b0, ph});
    check(busy === 1'b1, req, busy, 1);
    @(negedge clk);
    check(lines() == ph && oe === 1'b1, req, lines(), ph);
    wait_settle(n, req);
  endtask

  task automatic t_reset();
    check(lines() == 0 && oe === 0, "R1", lines(), 0);
    check(busy === 0 && flag === 0, "R1", {busy, flag}, 0);
  endtask

  task automatic t_same();
    strobe(4'b0001);
    check(busy === 0, "R2", busy, 0);
    @(negedge clk);
    check(busy === 0 && lines() == 1, "R2", lines(), 1);
  endtask

  task automatic t_ack_hold();
    ack = 1;
    strobe(4'b0111);
    repeat (5) @(negedge clk);
    check(lines() == 0 && busy === 1, "R3", lines(), 0);
    ack = 0;
    check(lines() == 0, "R4", lines(), 0);
    @(negedge clk);
    check(lines() == 7, "R4", lines(), 7);
    wait_settle(100, "R6");
  endtask

  task automatic t_release(input string req);
    strobe(4'b1000);
    @(negedge clk);
    check(lines() == 0 && oe === 0, req, lines(), 0);
    check(busy === 0, "R9", busy, 0);
    check(flag === 0, "R13", flag, 0);
  endtask

  task automatic t_leg_data();
    strobe(4'b0001);
    repeat (50000) @(negedge clk);
    check(lines() == 2, "R8", lines(), 2);
    @(negedge clk);
    check(lines() == 1, "R8", lines(), 1);
    wait_settle(50 + 50 + 12500, "R7");
  endtask

  task automatic t_dma();
    dmai = 0;
    strobe(4'b0000);
    @(negedge clk);
    check(lines() == 1 && busy === 0, "R10", lines(), 1);
    check(flag === 1, "R10", flag, 1);
    dmai = 1;
  endtask

  task automatic t_filter();
    @(negedge clk); brst = 1;
    repeat (10) @(negedge clk); brst = 0;
    repeat (80) @(negedge clk);
    check(flag === 0, "R11 glitch", flag, 0);
    seld = 1; brst = 1;
    repeat (100) @(negedge clk);
    check(flag === 0, "R11 sel", flag, 0);
    brst = 0; seld = 0;
    @(negedge clk); brst = 1;
    repeat (63) @(negedge clk);
    check(flag === 0, "R11 early", flag, 0);
    @(negedge clk);
    check(flag === 1, "R11", flag, 1);
  endtask

  task automatic t_abandon();
    ack = 1;
    strobe(4'b0010);
    @(negedge clk);
    check(lines() == 2, "R12", lines(), 2);
    wait_settle(50, "R12");
    ack = 0; brst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_enter(3'b010, 50, "R5");
    t_enter(3'b001, 100, "R6");
    t_same();
    t_enter(3'b000, 100, "R6");
    t_ack_hold();
    t_release("R9");
    leg = 1;
    t_enter(3'b010, 50 + 12500, "R7");
    t_leg_data();
    leg = 0;
    t_dma();
    t_release("R13");
    t_filter();
    t_abandon();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule